// File: doc/BRIEF.md
# Flash Status Byte and Suspend Tracker

This block holds the status byte of a NOR flash device. It follows the internal program/erase engine through its handshakes: operation start, completion, and the pause that answers a suspend request. From these it derives a ready flag, two suspend flags (one for erase, one for program) and four sticky error flags. Decoded command strobes drive it: read status, clear status, read array, suspend and resume. A read-path select tells the bus logic whether a read should return status data or array data.

The byte shown on `status_q` tracks the internal state one cycle late while the device is not being read. When chip enable and output enable become jointly asserted, the byte is frozen. It stays frozen until either enable is released, so one bus read sees one consistent value. Each suspend flag only shows while the engine is idle. Error flags stay set until a clear-status command or a hardware reset.

Top module: `flash_status_unit`

## Requirements
- R1: During and after reset (`rst` high), `status_q` reads 8'h80 and `sel_status` reads 0, which selects array data.
- R2: An accepted `eng_start` (engine idle, no resume in the same cycle) drives bit 7 to 0. An `eng_done` while busy returns bit 7 to 1.
- R3: A `cmd_suspend` during a busy operation leaves bit 7 at 0 until `eng_paused` arrives.
- R4: When `eng_paused` answers a pending suspend of an erase, bit 6 becomes 1 and bit 7 becomes 1. A `cmd_resume` while suspended clears bit 6 and makes the engine busy again (bit 7 = 0).
- R5: If `eng_done` arrives while a suspend is still pending, the operation completes: bit 7 goes to 1, bits 6 and 2 stay 0, and a later `eng_paused` has no effect.
- R6: When `eng_paused` answers a pending suspend of a program, bit 2 becomes 1. Resume clears it.
- R7: While bit 7 is 0, bits 6 and 2 read 0 even if a suspend is recorded. The recorded flag reappears once the engine is idle again. An example is a program run during an erase suspend.
- R8: Error report lines `eng_err[0..3]` set status bits 1, 3, 4 and 5 respectively. The bits stay set with no further reports.
- R9: `cmd_clr_status` clears all error bits. An error report in the same cycle as a clear wins for its own bit.
- R10: Bit 0 always reads 0.
- R11: `cmd_rd_array` sets `sel_status` to 0 and wins over everything else. `cmd_rd_status`, an accepted start or an accepted resume set it to 1.
- R12: When `ce_n` and `oe_n` become both low, `status_q` captures the current status and holds it while both stay low. With either enable high it follows the internal status one cycle late.
- R13: A hardware reset clears both suspend flags and all error bits and forces bit 7 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| cmd_rd_status | input | 1 | Decoded read-status command strobe |
| cmd_clr_status | input | 1 | Decoded clear-status command strobe |
| cmd_rd_array | input | 1 | Decoded read-array command strobe |
| cmd_suspend | input | 1 | Decoded suspend command strobe |
| cmd_resume | input | 1 | Decoded resume command strobe |
| eng_start | input | 1 | Engine begins an operation |
| eng_is_erase | input | 1 | Operation starting is an erase (1) or program (0) |
| eng_done | input | 1 | Engine finished the running operation |
| eng_paused | input | 1 | Engine has paused after a suspend request |
| eng_err | input | 4 | Per-category error reports |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| status_q | output | 8 | Status byte as presented to the bus |
| sel_status | output | 1 | 1: reads return status, 0: reads return array |

## Verification
A wrong busy or pending-suspend state appears on bit 7 two clock edges after the handshake that should have moved it, as long as the enables are released. A lost suspend flag stays hidden while the engine is busy and only shows when bit 7 returns to 1. The check therefore waits for the next idle point after a program run inside an erase suspend. Error flag faults show as a missing or surviving bit right after a report or clear. A capture fault shows as a byte that changes while both enables are held low.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int ST_W      = 8;
  localparam int N_ERR_CAT = 4;
  localparam int READY_B   = 7;
  localparam int ESUSP_B   = 6;
  localparam int PSUSP_B   = 2;

  // status bit that carries each error category
  function automatic int err_pos(input int cat);
    case (cat)
      0:       return 1;
      1:       return 3;
      2:       return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/fsr_err_bank.sv
module fsr_err_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr)    flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/fsr_op_tracker.sv
module fsr_op_tracker (
  input  logic clk,
  input  logic rst,
  input  logic cmd_rd_status,
  input  logic cmd_rd_array,
  input  logic cmd_suspend,
  input  logic cmd_resume,
  input  logic eng_start,
  input  logic eng_is_erase,
  input  logic eng_done,
  input  logic eng_paused,
  output logic busy,
  output logic susp_erase,
  output logic susp_prog,
  output logic sel_status
);
  logic op_erase, pend;
  logic resume_ok, start_ok, susp_ok;

  always_comb begin
    resume_ok = !busy && cmd_resume && (susp_erase || susp_prog);
    start_ok  = !busy && eng_start && !resume_ok;
    susp_ok   = busy && cmd_suspend && !pend && !susp_erase && !susp_prog;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      pend       <= 1'b0;
      op_erase   <= 1'b0;
      susp_erase <= 1'b0;
      susp_prog  <= 1'b0;
    end else if (busy) begin
      if (eng_done) begin
        busy <= 1'b0;
        pend <= 1'b0;
      end else if (pend && eng_paused) begin
        busy <= 1'b0;
        pend <= 1'b0;
        if (op_erase) susp_erase <= 1'b1;
        else          susp_prog  <= 1'b1;
      end else if (susp_ok) begin
        pend <= 1'b1;
      end
    end else if (resume_ok) begin
      busy       <= 1'b1;
      op_erase   <= susp_erase;
      susp_erase <= 1'b0;
      susp_prog  <= 1'b0;
    end else if (start_ok) begin
      busy     <= 1'b1;
      op_erase <= eng_is_erase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                      sel_status <= 1'b0;
    else if (cmd_rd_array)                        sel_status <= 1'b0;
    else if (cmd_rd_status || start_ok || resume_ok) sel_status <= 1'b1;
  end
endmodule

// File: rtl/fsr_out_latch.sv
module fsr_out_latch #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic [W-1:0] live,
  output logic [W-1:0] q
);
  logic act, act_d;
  assign act = !ce_n && !oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d <= 1'b0;
      q     <= RST_VAL;
    end else begin
      act_d <= act;
      if (!act || !act_d) q <= live;
    end
  end
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsr_pkg::*;
#(
  parameter int N_ERR = N_ERR_CAT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_rd_status,
  input  logic             cmd_clr_status,
  input  logic             cmd_rd_array,
  input  logic             cmd_suspend,
  input  logic             cmd_resume,
  input  logic             eng_start,
  input  logic             eng_is_erase,
  input  logic             eng_done,
  input  logic             eng_paused,
  input  logic [N_ERR-1:0] eng_err,
  input  logic             ce_n,
  input  logic             oe_n,
  output logic [ST_W-1:0]  status_q,
  output logic             sel_status
);
  localparam logic [ST_W-1:0] IDLE_VAL = ST_W'(1) << READY_B;

  logic             busy, susp_erase, susp_prog;
  logic [N_ERR-1:0] err_flags;
  logic [ST_W-1:0]  live;

  fsr_op_tracker u_trk (
    .clk(clk), .rst(rst),
    .cmd_rd_status(cmd_rd_status), .cmd_rd_array(cmd_rd_array),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
    .eng_start(eng_start), .eng_is_erase(eng_is_erase),
    .eng_done(eng_done), .eng_paused(eng_paused),
    .busy(busy), .susp_erase(susp_erase), .susp_prog(susp_prog),
    .sel_status(sel_status)
  );

  fsr_err_bank #(.N(N_ERR)) u_err (
    .clk(clk), .rst(rst), .clr(cmd_clr_status),
    .set(eng_err), .flags(err_flags)
  );

  always_comb begin
    live          = '0;
    live[READY_B] = !busy;
    live[ESUSP_B] = susp_erase && !busy;
    live[PSUSP_B] = susp_prog && !busy;
    for (int i = 0; i < N_ERR; i++) live[err_pos(i)] = err_flags[i];
  end

  fsr_out_latch #(.W(ST_W), .RST_VAL(IDLE_VAL)) u_lat (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n),
    .live(live), .q(status_q)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
  input logic       clk,
  input logic       rst,
  input logic       ce_n,
  input logic       oe_n,
  input logic       cmd_rd_status,
  input logic       cmd_rd_array,
  input logic       err_lo,
  input logic [7:0] status_q,
  input logic       sel_status
);
  logic act;
  assign act = !ce_n && !oe_n;

  // R1
  reset_sel_chk: assert property (@(posedge clk) rst |=> (sel_status == 1'b0));

  // R10
  bit0_zero_chk: assert property (@(posedge clk) disable iff (rst) status_q[0] == 1'b0);

  // R11
  rd_array_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_rd_array |=> !sel_status);

  // R11
  rd_status_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd_status && !cmd_rd_array) |=> sel_status);

  // R12
  hold_while_read_chk: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act) && !$past(rst)) |=> $stable(status_q));

  // R8
  err_shows_chk: assert property (@(posedge clk) disable iff (rst)
    (err_lo ##1 !act) |=> status_q[1]);
endmodule

bind flash_status_unit fsr_checker u_fsr_checker (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n),
  .cmd_rd_status(cmd_rd_status), .cmd_rd_array(cmd_rd_array),
  .err_lo(eng_err[0]), .status_q(status_q), .sel_status(sel_status)
);

// File: tb/test_flash_status_unit.sv
module test_flash_status_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_rd_status = 0, cmd_clr_status = 0, cmd_rd_array = 0;
  logic cmd_suspend = 0, cmd_resume = 0;
  logic eng_start = 0, eng_is_erase = 0, eng_done = 0, eng_paused = 0;
  logic [3:0] eng_err = '0;
  logic ce_n = 1'b1, oe_n = 1'b1;
  logic [7:0] status_q;
  logic sel_status;

  int n_chk = 0;
  int n_fail = 0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  flash_status_unit i_flash_status_unit (
    .clk(clk), .rst(rst),
    .cmd_rd_status(cmd_rd_status), .cmd_clr_status(cmd_clr_status),
    .cmd_rd_array(cmd_rd_array), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .eng_start(eng_start),
    .eng_is_erase(eng_is_erase), .eng_done(eng_done),
    .eng_paused(eng_paused), .eng_err(eng_err),
    .ce_n(ce_n), .oe_n(oe_n),
    .status_q(status_q), .sel_status(sel_status)
  );

  // reference model built from the requirements
  bit m_busy, m_pend, m_ope, m_se, m_sp, m_sel, m_actd;
  bit [3:0] m_err;
  bit [7:0] m_sq;

  function automatic bit [7:0] m_live(bit b, bit se, bit sp, bit [3:0] e);
    return {!b, se && !b, e[3], e[2], e[1], sp && !b, e[0], 1'b0};
  endfunction

  always @(posedge clk) begin
    bit act, r_ok, s_ok, p_ok;
    if (rst) begin
      m_busy = 0; m_pend = 0; m_ope = 0; m_se = 0; m_sp = 0;
      m_err = 0; m_sel = 0; m_sq = 8'h80; m_actd = 0;
    end else begin
      act = !ce_n && !oe_n;
      if (!act || !m_actd) m_sq = m_live(m_busy, m_se, m_sp, m_err);
      m_actd = act;
      m_err = (cmd_clr_status ? 4'b0 : m_err) | eng_err;
      r_ok = !m_busy && cmd_resume && (m_se || m_sp);
      s_ok = !m_busy && eng_start && !r_ok;
      p_ok = m_busy && cmd_suspend && !m_pend && !m_se && !m_sp;
      if (cmd_rd_array) m_sel = 0;
      else if (cmd_rd_status || s_ok || r_ok) m_sel = 1;
      if (m_busy) begin
        if (eng_done) begin m_busy = 0; m_pend = 0; end
        else if (m_pend && eng_paused) begin
          m_busy = 0; m_pend = 0;
          if (m_ope) m_se = 1; else m_sp = 1;
        end else if (p_ok) m_pend = 1;
      end else if (r_ok) begin
        m_busy = 1; m_ope = m_se; m_se = 0; m_sp = 0;
      end else if (s_ok) begin
        m_busy = 1; m_ope = eng_is_erase;
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    cmd_rd_status = 0; cmd_clr_status = 0; cmd_rd_array = 0;
    cmd_suspend = 0; cmd_resume = 0; eng_start = 0; eng_done = 0;
    eng_paused = 0; eng_err = '0;
  endtask

  // strobes set by caller before this; one edge with them, one more edge, then sample
  task automatic fire();
    @(negedge clk); idle(); @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status during reset", status_q, 8'h80);
    chk("R1 sel during reset", {7'd0, sel_status}, 8'h00);
    rst = 0;
    @(negedge clk);
    chk("R1 status after reset", status_q, 8'h80);

    eng_start = 1; eng_is_erase = 1; fire();
    chk("R2 busy after erase start", status_q, 8'h00);
    chk("R11 sel after start", {7'd0, sel_status}, 8'h01);
    cmd_suspend = 1; fire();
    chk("R3 still busy until paused", status_q, 8'h00);
    @(negedge clk);
    chk("R3 still busy later", status_q, 8'h00);
    eng_paused = 1; fire();
    chk("R4 erase suspended", status_q, 8'hC0);
    eng_start = 1; eng_is_erase = 0; fire();
    chk("R7 bit6 masked while busy", status_q, 8'h00);
    eng_done = 1; fire();
    chk("R7 bit6 back when idle", status_q, 8'hC0);
    cmd_resume = 1; fire();
    chk("R4 resume clears bit6", status_q, 8'h00);
    eng_done = 1; fire();
    chk("R2 done returns ready", status_q, 8'h80);

    eng_start = 1; eng_is_erase = 1; fire();
    cmd_suspend = 1; fire();
    eng_done = 1; fire();
    chk("R5 done in latency window", status_q, 8'h80);
    eng_paused = 1; fire();
    chk("R5 late pause ignored", status_q, 8'h80);

    eng_start = 1; eng_is_erase = 0; fire();
    cmd_suspend = 1; fire();
    eng_paused = 1; fire();
    chk("R6 program suspended", status_q, 8'h84);
    cmd_resume = 1; fire();
    chk("R6 resume clears bit2", status_q, 8'h00);
    eng_done = 1; fire();
    chk("R6 program done", status_q, 8'h80);

    eng_err = 4'b1111; fire();
    chk("R8 all errors set", status_q, 8'hBA);
    repeat (4) @(negedge clk);
    chk("R8 errors sticky", status_q, 8'hBA);
    cmd_clr_status = 1; eng_err = 4'b0001; fire();
    chk("R9 set wins over clear", status_q, 8'h82);
    cmd_clr_status = 1; fire();
    chk("R9 clear", status_q, 8'h80);
    chk("R10 bit0 zero", {7'd0, status_q[0]}, 8'h00);

    cmd_rd_array = 1; fire();
    chk("R11 read array", {7'd0, sel_status}, 8'h00);
    cmd_rd_status = 1; fire();
    chk("R11 read status", {7'd0, sel_status}, 8'h01);
    cmd_rd_array = 1; eng_start = 1; eng_is_erase = 1; fire();
    chk("R11 array wins over start", {7'd0, sel_status}, 8'h00);
    eng_done = 1; fire();

    ce_n = 0; oe_n = 0; @(negedge clk);
    eng_err = 4'b1000; @(negedge clk); idle();
    repeat (3) @(negedge clk);
    chk("R12 held while enabled", status_q, 8'h80);
    oe_n = 1; @(negedge clk);
    chk("R12 follows after release", status_q, 8'hA0);
    oe_n = 0; @(negedge clk);
    cmd_clr_status = 1; @(negedge clk); idle();
    repeat (2) @(negedge clk);
    chk("R12 oe falling capture held", status_q, 8'hA0);
    ce_n = 1; oe_n = 1; @(negedge clk);
    chk("R12 follows after ce release", status_q, 8'h80);

    eng_err = 4'b0110; eng_start = 1; eng_is_erase = 1; fire();
    cmd_suspend = 1; fire();
    eng_paused = 1; fire();
    chk("R13 pre-reset state", status_q, 8'hD8);
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    chk("R13 reset clears flags", status_q, 8'h80);
    chk("R13 reset sel", {7'd0, sel_status}, 8'h00);

    // constrained random phase against the model
    model_on = 1;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      idle();
      r = $urandom_range(0, 99);
      rst            = ($urandom_range(0, 599) == 0);
      eng_start      = (r < 12);
      eng_is_erase   = $urandom_range(0, 1);
      eng_done       = (r >= 12 && r < 20);
      eng_paused     = (r >= 20 && r < 30);
      cmd_suspend    = (r >= 30 && r < 40);
      cmd_resume     = (r >= 40 && r < 48);
      cmd_rd_status  = (r >= 48 && r < 52);
      cmd_rd_array   = (r >= 52 && r < 56);
      cmd_clr_status = (r >= 56 && r < 60);
      eng_err        = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(1, 15)) : 4'b0;
      if ($urandom_range(0, 7) == 0) ce_n = ~ce_n;
      if ($urandom_range(0, 5) == 0) oe_n = ~oe_n;
      @(negedge clk);
      chk("R2-model status", status_q, m_sq);
      chk("R11 model sel", {7'd0, sel_status}, {7'd0, m_sel});
      chk("R10 random bit0", {7'd0, status_q[0]}, 8'h00);
    end
    idle(); rst = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule